// File: doc/BRIEF.md
# OUT Endpoint Packet Receiver

This block is the receive side of a device OUT endpoint. The protocol layer hands it each decoded data packet as a start strobe, a stream of bytes and an end strobe, with a CRC-error flag valid at the end strobe. The block stores accepted packets in a small ring of packet buffers and answers each packet with a handshake code. Firmware sees a set of status bits, unloads the oldest stored packet one byte at a time, and releases its buffer when done.

The endpoint works in one of two configurations. In bulk/interrupt mode a good packet is acknowledged, a packet that finds no free buffer is refused with NAK, and a corrupted packet is dropped without a reply. In isochronous mode no handshake is returned, a packet that finds no free buffer sets a sticky overrun flag and is lost, and a corrupted packet is still stored but carries a data-error mark. In either mode a firmware stall request makes the endpoint discard incoming packets and answer each with STALL once its data phase ends. An optional auto-release mode frees the buffer by itself once a full-size bulk packet has been read out.

Top module: `ep_out_rx`

## Requirements
- R1: After reset, hs_valid, pkt_ready, pkt_len, data_error, stall_req, sent_stall, overrun and irq are all 0.
- R2: In bulk mode a packet whose end strobe has pkt_crc_err = 0, and which finds a free buffer at its start strobe, is stored; pkt_len then shows its byte count (bytes beyond MAX_PKT are dropped) and fw_rd_data presents its bytes in arrival order, advancing by one on each fw_rd_en.
- R3: In bulk mode a packet that starts while all NUM_BUF buffers hold unreleased packets is not stored and is answered with NAK.
- R4: In bulk mode a packet ending with pkt_crc_err = 1 is not stored and gets no handshake.
- R5: While stall_req is 1 at a start strobe, that packet is discarded, STALL is returned after its end strobe, and sent_stall becomes 1 in the same cycle as the STALL handshake.
- R6: fw_stall_set sets stall_req and fw_stall_clr clears it; once cleared, the next packet is handled normally. fw_sent_stall_clr clears sent_stall.
- R7: In isochronous mode a packet that starts with no free buffer sets overrun (one cycle after the start strobe), is not stored, and gets no handshake; overrun stays 1 until fw_overrun_clr.
- R8: In isochronous mode a packet ending with pkt_crc_err = 1 is stored with data_error = 1 while it is the oldest stored packet; no handshake is returned for any isochronous packet other than STALL.
- R9: pkt_ready is 1 while any packet is stored; fw_ready_clr releases the oldest packet, after which the next stored packet (if any) is shown.
- R10: With cfg_autoclr = 1 in bulk mode, reading the last byte of a packet of exactly MAX_PKT bytes releases it; shorter packets and isochronous packets are not released by reading.
- R11: irq equals irq_en AND (pkt_ready OR sent_stall).
- R12: A handshake appears as a one-cycle hs_valid pulse in the cycle after the end strobe, with hs_code ACK = 2'b01, NAK = 2'b10, STALL = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_iso | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| cfg_autoclr | input | 1 | Enable automatic release of full-size bulk packets |
| irq_en | input | 1 | Endpoint interrupt enable |
| pkt_start | input | 1 | Start of a data packet |
| pkt_valid | input | 1 | pkt_data holds a packet byte |
| pkt_data | input | 8 | Packet byte |
| pkt_end | input | 1 | End of the data packet |
| pkt_crc_err | input | 1 | Packet failed its CRC, valid with pkt_end |
| hs_valid | output | 1 | Handshake request pulse |
| hs_code | output | 2 | Handshake code |
| fw_stall_set | input | 1 | Firmware sets the stall request |
| fw_stall_clr | input | 1 | Firmware clears the stall request |
| fw_sent_stall_clr | input | 1 | Firmware clears sent_stall |
| fw_overrun_clr | input | 1 | Firmware clears overrun |
| fw_ready_clr | input | 1 | Firmware releases the oldest packet |
| fw_rd_en | input | 1 | Firmware read strobe, advances the read byte |
| fw_rd_data | output | 8 | Current byte of the oldest packet |
| pkt_ready | output | 1 | A stored packet is available |
| pkt_len | output | 4 | Byte count of the oldest packet |
| data_error | output | 1 | Oldest packet was stored with a CRC error |
| stall_req | output | 1 | Stall request state |
| sent_stall | output | 1 | A STALL handshake has been sent |
| overrun | output | 1 | Sticky isochronous overrun |
| irq | output | 1 | Interrupt request |

## Verification
The receiver is driven with short and full-size bulk packets, back-to-back packets that fill every buffer before a third arrives, packets flagged with a CRC error in each mode, and packets arriving while a stall is requested and after it is withdrawn. The fill pattern separates NAK from ACK and overrun from storage, the CRC cases separate drop-in-bulk from keep-and-mark-in-isochronous, and full-size against short reads under auto-release show whether the release is tied to exactly MAX_PKT bytes and to bulk mode only. A behavioural model with byte queues predicts every output each cycle, so ordering of stored bytes across buffer wrap is also compared.

// File: rtl/ep_rx_pkg.sv
// Shared types for the OUT endpoint receiver.
// Assumes: handshake codes are consumed by a neighbouring protocol layer.
package ep_rx_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_STORE = 2'b01,
        RX_FULL  = 2'b10,
        RX_STALL = 2'b11
    } rx_state_e;
endpackage

// File: rtl/ep_rx_ctrl.sv
// Receive control: classifies each packet at its start strobe, counts and
// forwards bytes to the buffer ring, commits at the end strobe, and keeps the
// stall / sent-stall / overrun status.
// Assumes: pkt_start and pkt_end are single-cycle and never coincide.
module ep_rx_ctrl
    import ep_rx_pkg::*;
#(
    parameter int MAX_PKT = 8,
    parameter int DW      = 8,
    localparam int LEN_W  = $clog2(MAX_PKT + 1),
    localparam int OFS_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_iso,
    input  logic             pkt_start,
    input  logic             pkt_valid,
    input  logic [DW-1:0]    pkt_data,
    input  logic             pkt_end,
    input  logic             pkt_crc_err,
    input  logic             buf_full,
    input  logic             fw_stall_set,
    input  logic             fw_stall_clr,
    input  logic             fw_sent_stall_clr,
    input  logic             fw_overrun_clr,
    output logic             wr_en,
    output logic [OFS_W-1:0] wr_ofs,
    output logic [DW-1:0]    wr_data,
    output logic             commit,
    output logic [LEN_W-1:0] commit_len,
    output logic             commit_err,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             stall_req,
    output logic             sent_stall,
    output logic             overrun
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PKT);

    rx_state_e        state;
    logic [LEN_W-1:0] cnt;
    logic             iso_q;
    logic             ending;

    // Byte path and commit decision for the packet being received.
    always_comb begin
        ending     = pkt_end && (state != RX_IDLE);
        wr_en      = (state == RX_STORE) && pkt_valid && (cnt < MAX_L);
        wr_ofs     = cnt[OFS_W-1:0];
        wr_data    = pkt_data;
        commit     = (state == RX_STORE) && pkt_end && (!pkt_crc_err || iso_q);
        commit_len = cnt;
        commit_err = pkt_crc_err;
    end

    // Packet classification state and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            iso_q <= 1'b0;
        end else if (pkt_start) begin
            cnt   <= '0;
            iso_q <= cfg_iso;
            if (stall_req)     state <= RX_STALL;
            else if (buf_full) state <= RX_FULL;
            else               state <= RX_STORE;
        end else if (pkt_end) begin
            state <= RX_IDLE;
        end else if (wr_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Handshake selection, registered one cycle after the end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= 1'b0;
            if (ending) begin
                unique case (state)
                    RX_STORE: if (!iso_q && !pkt_crc_err) begin
                        hs_valid <= 1'b1;
                        hs_code  <= HS_ACK;
                    end
                    RX_FULL: if (!iso_q) begin
                        hs_valid <= 1'b1;
                        hs_code  <= HS_NAK;
                    end
                    RX_STALL: begin
                        hs_valid <= 1'b1;
                        hs_code  <= HS_STALL;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Firmware-visible status bits; a hardware set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_req  <= 1'b0;
            sent_stall <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (fw_stall_set)      stall_req <= 1'b1;
            else if (fw_stall_clr) stall_req <= 1'b0;

            if (ending && state == RX_STALL) sent_stall <= 1'b1;
            else if (fw_sent_stall_clr)      sent_stall <= 1'b0;

            if (pkt_start && cfg_iso && !stall_req && buf_full) overrun <= 1'b1;
            else if (fw_overrun_clr)                            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/ep_rx_bufring.sv
// Ring of NUM_BUF packet buffers of MAX_PKT bytes. The tail buffer is written
// in place and becomes visible only on commit; pop releases the head buffer.
// Assumes: commit is never requested while full.
module ep_rx_bufring #(
    parameter int MAX_PKT = 8,
    parameter int NUM_BUF = 2,
    parameter int DW      = 8,
    localparam int LEN_W  = $clog2(MAX_PKT + 1),
    localparam int OFS_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int CNT_W  = $clog2(NUM_BUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [DW-1:0]    wr_data,
    input  logic             commit,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             commit_err,
    input  logic             pop,
    input  logic [OFS_W-1:0] rd_ofs,
    output logic             full,
    output logic             head_valid,
    output logic [LEN_W-1:0] head_len,
    output logic             head_err,
    output logic [DW-1:0]    head_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

    logic [DW-1:0]    mem   [NUM_BUF][MAX_PKT];
    logic [LEN_W-1:0] len_q [NUM_BUF];
    logic [NUM_BUF-1:0] err_q;
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count;

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

    // Head-buffer view for the firmware side.
    always_comb begin
        full       = (count == CNT_W'(NUM_BUF));
        head_valid = (count != '0);
        head_len   = len_q[head];
        head_err   = err_q[head];
        head_data  = mem[head][rd_ofs];
    end

    // Byte storage into the tail buffer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[tail][wr_ofs] <= wr_data;
    end

    // Ring pointers, occupancy and per-buffer descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            err_q <= '0;
            for (int b = 0; b < NUM_BUF; b++) len_q[b] <= '0;
        end else begin
            if (commit) begin
                len_q[tail] <= commit_len;
                err_q[tail] <= commit_err;
                tail        <= nxt(tail);
            end
            if (pop && head_valid) head <= nxt(head);
            case ({commit, pop && head_valid})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ep_rx_reader.sv
// Firmware unload side: byte read pointer into the head packet, and release
// of the head buffer by firmware or by auto-release after a full-size bulk read.
// Assumes: the read pointer saturates on the last byte slot.
module ep_rx_reader #(
    parameter int MAX_PKT = 8,
    localparam int LEN_W  = $clog2(MAX_PKT + 1),
    localparam int OFS_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_iso,
    input  logic             cfg_autoclr,
    input  logic             fw_rd_en,
    input  logic             fw_ready_clr,
    input  logic             head_valid,
    input  logic [LEN_W-1:0] head_len,
    output logic [OFS_W-1:0] rd_ofs,
    output logic             pop
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(MAX_PKT - 1);
    localparam logic [LEN_W-1:0] MAX_L    = LEN_W'(MAX_PKT);

    logic auto_rel;

    // Release decision for the head buffer.
    always_comb begin
        auto_rel = cfg_autoclr && !cfg_iso && fw_rd_en &&
                   (rd_ofs == LAST_OFS) && (head_len == MAX_L);
        pop      = head_valid && (fw_ready_clr || auto_rel);
    end

    // Read pointer: reset on release, step on each read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         rd_ofs <= '0;
        else if (pop)                                       rd_ofs <= '0;
        else if (fw_rd_en && head_valid && rd_ofs != LAST_OFS) rd_ofs <= rd_ofs + 1'b1;
    end
endmodule

// File: rtl/ep_out_rx.sv
// OUT endpoint receiver top: joins the receive control, the packet buffer
// ring and the firmware reader, and forms the firmware status and interrupt.
// Assumes: one packet in flight at a time from the protocol layer.
module ep_out_rx #(
    parameter int MAX_PKT = 8,
    parameter int NUM_BUF = 2,
    parameter int DW      = 8,
    localparam int LEN_W  = $clog2(MAX_PKT + 1),
    localparam int OFS_W  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_iso,
    input  logic             cfg_autoclr,
    input  logic             irq_en,
    input  logic             pkt_start,
    input  logic             pkt_valid,
    input  logic [DW-1:0]    pkt_data,
    input  logic             pkt_end,
    input  logic             pkt_crc_err,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    input  logic             fw_stall_set,
    input  logic             fw_stall_clr,
    input  logic             fw_sent_stall_clr,
    input  logic             fw_overrun_clr,
    input  logic             fw_ready_clr,
    input  logic             fw_rd_en,
    output logic [DW-1:0]    fw_rd_data,
    output logic             pkt_ready,
    output logic [LEN_W-1:0] pkt_len,
    output logic             data_error,
    output logic             stall_req,
    output logic             sent_stall,
    output logic             overrun,
    output logic             irq
);
    logic             wr_en, commit, commit_err, buf_full, pop;
    logic [OFS_W-1:0] wr_ofs, rd_ofs;
    logic [DW-1:0]    wr_data;
    logic [LEN_W-1:0] commit_len, head_len;
    logic             head_valid, head_err;

    ep_rx_ctrl #(.MAX_PKT(MAX_PKT), .DW(DW)) u_ctrl (
        .clk, .rst_n, .cfg_iso, .pkt_start, .pkt_valid, .pkt_data, .pkt_end,
        .pkt_crc_err, .buf_full, .fw_stall_set, .fw_stall_clr,
        .fw_sent_stall_clr, .fw_overrun_clr, .wr_en, .wr_ofs, .wr_data,
        .commit, .commit_len, .commit_err, .hs_valid, .hs_code,
        .stall_req, .sent_stall, .overrun
    );

    ep_rx_bufring #(.MAX_PKT(MAX_PKT), .NUM_BUF(NUM_BUF), .DW(DW)) u_ring (
        .clk, .rst_n, .wr_en, .wr_ofs, .wr_data, .commit, .commit_len,
        .commit_err, .pop, .rd_ofs, .full(buf_full), .head_valid, .head_len,
        .head_err, .head_data(fw_rd_data)
    );

    ep_rx_reader #(.MAX_PKT(MAX_PKT)) u_rd (
        .clk, .rst_n, .cfg_iso, .cfg_autoclr, .fw_rd_en, .fw_ready_clr,
        .head_valid, .head_len, .rd_ofs, .pop
    );

    // Firmware status view of the oldest packet and the interrupt request.
    always_comb begin
        pkt_ready  = head_valid;
        pkt_len    = head_valid ? head_len : '0;
        data_error = head_valid && head_err;
        irq        = irq_en && (head_valid || sent_stall);
    end
endmodule

// File: rtl/ep_out_rx_chk.sv
// Temporal checks on the OUT endpoint receiver ports, attached by bind.
module ep_out_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_iso,
    input logic       pkt_end,
    input logic       pkt_crc_err,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       sent_stall,
    input logic       overrun,
    input logic       pkt_ready,
    input logic       fw_ready_clr,
    input logic       fw_rd_en
);
    // R12
    hs_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(pkt_end));
    // R12
    hs_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);
    // R5
    stall_flag_with_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent_stall) |-> (hs_valid && hs_code == 2'b11));
    // R7
    overrun_iso_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(cfg_iso));
    // R3
    nak_bulk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b10) |-> !$past(cfg_iso));
    // R4
    ack_clean_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b01) |-> !$past(pkt_crc_err));
    // R9
    ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pkt_ready) |-> $past(fw_ready_clr || fw_rd_en));
endmodule

bind ep_out_rx ep_out_rx_chk u_chk (.*);

// File: tb/ep_out_rx_test.sv
module ep_out_rx_test;
    localparam int MAXP = 8;
    localparam int NB   = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_iso = 0, cfg_autoclr = 0, irq_en = 0;
    logic pkt_start = 0, pkt_valid = 0, pkt_end = 0, pkt_crc_err = 0;
    logic [7:0] pkt_data = 0;
    logic fw_stall_set = 0, fw_stall_clr = 0, fw_sent_stall_clr = 0;
    logic fw_overrun_clr = 0, fw_ready_clr = 0, fw_rd_en = 0;
    logic hs_valid, pkt_ready, data_error, stall_req, sent_stall, overrun, irq;
    logic [1:0] hs_code;
    logic [7:0] fw_rd_data;
    logic [3:0] pkt_len;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ep_out_rx #(.MAX_PKT(MAXP), .NUM_BUF(NB)) uut (.*);

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_bytes[$], cur[$];
    int m_len[$];
    bit m_err[$];
    int m_state = 0, m_rd = 0;  // 0 idle, 1 store, 2 no buffer, 3 stall
    bit m_iso = 0, m_stall = 0, m_sent = 0, m_ovr = 0, m_hsv = 0;
    logic [1:0] m_hsc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bytes.delete(); cur.delete(); m_len.delete(); m_err.delete();
            m_state = 0; m_rd = 0; m_iso = 0; m_stall = 0; m_sent = 0;
            m_ovr = 0; m_hsv = 0; m_hsc = 0;
        end else begin
            bit old_stall, full, ready, pop, stall_end;
            old_stall = m_stall;
            full  = (m_len.size() == NB);
            ready = (m_len.size() > 0);
            pop   = ready && (fw_ready_clr || (fw_rd_en && cfg_autoclr && !cfg_iso
                     && m_rd == MAXP-1 && m_len[0] == MAXP));
            m_hsv = 0;
            stall_end = 0;
            if (fw_overrun_clr) m_ovr = 0;
            if (pkt_start) begin
                cur.delete();
                m_iso = cfg_iso;
                m_state = old_stall ? 3 : (full ? 2 : 1);
                if (cfg_iso && !old_stall && full) m_ovr = 1;
            end else if (pkt_end && m_state != 0) begin
                if (m_state == 1) begin
                    if (!pkt_crc_err || m_iso) begin
                        foreach (cur[i]) m_bytes.push_back(cur[i]);
                        m_len.push_back(cur.size());
                        m_err.push_back(pkt_crc_err);
                    end
                    if (!m_iso && !pkt_crc_err) begin m_hsv = 1; m_hsc = 2'b01; end
                end else if (m_state == 2) begin
                    if (!m_iso) begin m_hsv = 1; m_hsc = 2'b10; end
                end else begin
                    m_hsv = 1; m_hsc = 2'b11; stall_end = 1;
                end
                m_state = 0;
            end else if (m_state == 1 && pkt_valid && cur.size() < MAXP) begin
                cur.push_back(pkt_data);
            end
            if (pop) begin
                for (int i = 0; i < m_len[0]; i++) void'(m_bytes.pop_front());
                void'(m_len.pop_front());
                void'(m_err.pop_front());
                m_rd = 0;
            end else if (fw_rd_en && ready && m_rd < MAXP-1) begin
                m_rd++;
            end
            if (stall_end) m_sent = 1;
            else if (fw_sent_stall_clr) m_sent = 0;
            if (fw_stall_set) m_stall = 1;
            else if (fw_stall_clr) m_stall = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit rdy;
            rdy = (m_len.size() > 0);
            check(hs_valid == m_hsv, "R12 hs_valid", hs_valid, m_hsv);
            if (m_hsv) check(hs_code == m_hsc, "R12 hs_code", hs_code, m_hsc);
            check(pkt_ready == rdy, "R9 pkt_ready", pkt_ready, rdy);
            check(pkt_len == (rdy ? m_len[0] : 0), "R2 pkt_len", pkt_len, rdy ? m_len[0] : 0);
            check(data_error == (rdy ? m_err[0] : 0), "R8 data_error", data_error, rdy ? m_err[0] : 0);
            if (rdy && m_rd < m_len[0])
                check(fw_rd_data == m_bytes[m_rd], "R2 fw_rd_data", fw_rd_data, m_bytes[m_rd]);
            check(stall_req == m_stall, "R6 stall_req", stall_req, m_stall);
            check(sent_stall == m_sent, "R5 sent_stall", sent_stall, m_sent);
            check(overrun == m_ovr, "R7 overrun", overrun, m_ovr);
            check(irq == (irq_en && (rdy || m_sent)), "R11 irq", irq, irq_en && (rdy || m_sent));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(negedge clk); #2;
    endtask

    task automatic send(input int n, input int base, input bit crc, output bit hv, output logic [1:0] hc);
        pkt_start = 1; tick(); pkt_start = 0;
        for (int i = 0; i < n; i++) begin
            pkt_valid = 1; pkt_data = 8'(base + i); tick();
        end
        pkt_valid = 0;
        pkt_end = 1; pkt_crc_err = crc;
        @(negedge clk); hv = hs_valid; hc = hs_code; #2;
        pkt_end = 0; pkt_crc_err = 0;
        tick();
    endtask

    task automatic read(input int n);
        for (int i = 0; i < n; i++) begin fw_rd_en = 1; tick(); end
        fw_rd_en = 0; tick();
    endtask

    task automatic pulse_clr();
        fw_ready_clr = 1; tick(); fw_ready_clr = 0; tick();
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit hv; logic [1:0] hc;
        tick(); tick();
        check({hs_valid, pkt_ready, pkt_len, data_error, stall_req, sent_stall, overrun, irq} == 0,
              "R1 reset state", pkt_ready, 0);
        rst_n = 1; irq_en = 1; tick();

        // Bulk good packet: ACK, store, read (R2, R12)
        send(5, 8'h10, 0, hv, hc);
        check(hv && hc == 2'b01, "R2 ack", hc, 1);
        read(5);
        pulse_clr();

        // Fill both buffers, third gets NAK (R3)
        send(3, 8'h20, 0, hv, hc);
        send(MAXP, 8'h30, 0, hv, hc);
        send(4, 8'h40, 0, hv, hc);
        check(hv && hc == 2'b10, "R3 nak", hc, 2);
        check(pkt_len == 3, "R3 not stored", pkt_len, 3);
        read(3); pulse_clr();
        read(MAXP); pulse_clr();

        // Bulk CRC error: dropped, no handshake (R4)
        send(4, 8'h50, 1, hv, hc);
        check(!hv && !pkt_ready, "R4 crc drop", hv, 0);

        // Auto-release (R10)
        cfg_autoclr = 1; tick();
        send(MAXP, 8'h60, 0, hv, hc);
        read(MAXP);
        check(!pkt_ready, "R10 full-size auto release", pkt_ready, 0);
        send(4, 8'h70, 0, hv, hc);
        read(4);
        check(pkt_ready, "R10 short packet kept", pkt_ready, 1);
        pulse_clr();

        // Stall (R5, R6)
        fw_stall_set = 1; tick(); fw_stall_set = 0; tick();
        send(3, 8'h80, 0, hv, hc);
        check(hv && hc == 2'b11, "R5 stall hs", hc, 3);
        check(sent_stall && !pkt_ready && irq, "R5 stall discard", pkt_ready, 0);
        fw_sent_stall_clr = 1; fw_stall_clr = 1; tick();
        fw_sent_stall_clr = 0; fw_stall_clr = 0; tick();
        send(2, 8'h90, 0, hv, hc);
        check(hv && hc == 2'b01, "R6 normal after stall", hc, 1);
        pulse_clr();

        // Isochronous: CRC error kept, overrun when full (R7, R8, R10)
        cfg_iso = 1; tick();
        send(MAXP, 8'hA0, 1, hv, hc);
        check(!hv && data_error, "R8 iso crc kept", data_error, 1);
        send(MAXP, 8'hB0, 0, hv, hc);
        send(2, 8'hC0, 0, hv, hc);
        check(!hv && overrun, "R7 overrun", overrun, 1);
        read(MAXP);
        check(pkt_ready && data_error, "R10 no auto release in iso", pkt_ready, 1);
        pulse_clr();
        check(!data_error && pkt_len == MAXP, "R9 next packet shown", pkt_len, MAXP);
        fw_overrun_clr = 1; tick(); fw_overrun_clr = 0; tick();
        check(!overrun, "R7 overrun cleared", overrun, 0);
        pulse_clr();
        irq_en = 0; tick(); tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule